// File: doc/BRIEF.md
# Mailbox Command Completion Sequencer

This block is the device side of a host-to-controller command mailbox. A host CPU writes the byte address of a command block into a one-deep command register. The sequencer takes that address, reads the 32-byte command block from shared memory and decodes it. A block flagged as packet-type names a separate command packet, which the sequencer then reads. The block then runs a stand-in execution step, writes a one-word result into the reply area that follows the packet, writes a completion code into the block's response word and, if enabled, pulses an interrupt.

The command register shows ready again as soon as the sequencer has taken the pending pointer. A ready register therefore means the previous command has started. It does not mean that command has finished. The host learns of completion from the response word, or from the interrupt when that is enabled. One further pointer can wait in the register while a command runs. A write made while the register is not ready is dropped and latched in a sticky overrun flag.

Command block layout (32-bit words, byte offsets from the block pointer): word 0 bits [7:0] hold the opcode and bit 8 the packet flag (1 = packet-type). Word 1 holds the packet byte address. Word 2 bits [15:0] hold the packet length in bytes. Word 7 (offset 28) is the response word. The sequencer visits its states in the order idle, block fetch, packet fetch (packet-type only), execute, reply write (packet-type only), status write, interrupt, and then back to idle.

Top module: `mbox_cmd_seq`

## Requirements
- R1: A write to the command register while `cmdReady` is 1 is accepted, and `cmdReady` reads 0 in the following cycle.
- R2: `cmdReady` returns to 1 in the cycle after the sequencer takes the pending pointer to begin processing. This happens one cycle after acceptance when the sequencer is idle, or as soon as the running command finishes when it is busy. Queued commands execute in acceptance order.
- R3: Every command starts with eight word reads at the block pointer + 0, 4, ..., 28. At most one memory read or write is issued per cycle.
- R4: For a packet-type block whose length L satisfies 4 <= L <= 248, the sequencer reads ceil(L/4) words starting at the packet pointer.
- R5: After such a packet read, one reply word is written at packet pointer + 4*ceil(L/4). Its value is the 32-bit wrap-around sum of the packet words plus the opcode.
- R6: The response word at block pointer + 28 receives 0x00000001 on success. It receives 0x00000080 when a packet-type block has L < 4 or L > 248. In that error case no packet word is read and no reply is written.
- R7: When `irqEnable` is 1, `irq` is a one-cycle pulse in the cycle right after the status write. When `irqEnable` is 0, `irq` stays 0.
- R8: A write while `cmdReady` is 0 is ignored: the pending pointer is kept and the dropped command never executes. `cmdOverrun` then reads 1 and stays 1 until reset.
- R9: A block with the packet flag at 0 causes no packet read and no reply write, and receives the success code.
- R10: For each command, the reply write (if any) comes before the status write, and the status write comes before the interrupt.
- R11: After reset, `cmdReady` is 1 and `cmdOverrun`, `irq`, `memRdEn` and `memWrEn` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWrEn | input | 1 | Host write strobe for the command register |
| cmdWrData | input | ADDR_W | Byte address of a command block |
| cmdReady | output | 1 | Command register can take a new pointer |
| cmdOverrun | output | 1 | Sticky: a write arrived while not ready |
| irqEnable | input | 1 | Enables the completion interrupt |
| irq | output | 1 | One-cycle completion pulse |
| memRdEn | output | 1 | Memory read request; data returns next cycle |
| memWrEn | output | 1 | Memory write strobe |
| memAddr | output | ADDR_W | Byte address of the access (word aligned) |
| memWrData | output | 32 | Write data |
| memRdData | input | 32 | Read data, valid one cycle after memRdEn |

## Verification
The hardest situation to reach is an overrun, because it needs a second pointer already pending behind a running command. A lone write on an idle sequencer is taken after one cycle and never blocks. The bench therefore starts a maximum-length packet command, and once `cmdReady` is back it writes a second pointer, which gets queued. It then writes a third pointer in the next cycle, while the register is still full. The scoreboard expects the full sequence of memory writes for the first two commands and nothing for the third, and `cmdOverrun` must read 1 and stay there.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int BLK_WORDS   = 8;
  localparam int RESP_OFFSET = 28;
  localparam int MIN_LEN     = 4;
  localparam int MAX_LEN     = 248;
  localparam int MAX_WORDS   = MAX_LEN / 4;
  localparam int IDX_W       = $clog2(MAX_WORDS + 1);

  localparam logic [7:0] CODE_OK     = 8'h01;
  localparam logic [7:0] CODE_BADLEN = 8'h80;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH_BLOCK,
    ST_FETCH_PACKET,
    ST_EXECUTE,
    ST_WRITE_REPLY,
    ST_WRITE_STATUS,
    ST_IRQ
  } seqState_t;

  typedef struct packed {
    logic             takePtr;
    logic             rdBlock;
    logic             rdPacket;
    logic [IDX_W-1:0] idx;
    logic             latchExec;
    logic             wrReply;
    logic             wrStatus;
    logic             statusErr;
  } seqStrobe_t;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             pendValid,
  input  logic             irqEnable,
  input  logic             rxValid,
  input  logic [IDX_W-1:0] rxIdx,
  input  logic             pktFlag,
  input  logic             lenOk,
  input  logic [IDX_W-1:0] pktWords,
  output seqStrobe_t       strb,
  output logic             irq
);
  localparam logic [IDX_W-1:0] BLK_LAST = IDX_W'(BLK_WORDS - 1);

  seqState_t        state, nextState;
  logic [IDX_W-1:0] idxQ;
  logic             issueDone;
  logic             errQ;
  logic [IDX_W-1:0] lastIdx;
  logic             badLenHit;

  assign lastIdx = (state == ST_FETCH_BLOCK) ? BLK_LAST : pktWords - IDX_W'(1);

  always_comb begin
    strb      = '0;
    nextState = state;
    badLenHit = 1'b0;
    case (state)
      ST_IDLE: begin
        if (pendValid) begin
          strb.takePtr = 1'b1;
          nextState    = ST_FETCH_BLOCK;
        end
      end
      ST_FETCH_BLOCK: begin
        strb.rdBlock = !issueDone;
        strb.idx     = idxQ;
        if (rxValid && rxIdx == BLK_LAST) begin
          if (pktFlag && lenOk) begin
            nextState = ST_FETCH_PACKET;
          end else if (pktFlag) begin
            nextState = ST_WRITE_STATUS;
            badLenHit = 1'b1;
          end else begin
            nextState = ST_EXECUTE;
          end
        end
      end
      ST_FETCH_PACKET: begin
        strb.rdPacket = !issueDone;
        strb.idx      = idxQ;
        if (rxValid && rxIdx == lastIdx) nextState = ST_EXECUTE;
      end
      ST_EXECUTE: begin
        strb.latchExec = 1'b1;
        nextState      = pktFlag ? ST_WRITE_REPLY : ST_WRITE_STATUS;
      end
      ST_WRITE_REPLY: begin
        strb.wrReply = 1'b1;
        nextState    = ST_WRITE_STATUS;
      end
      ST_WRITE_STATUS: begin
        strb.wrStatus  = 1'b1;
        strb.statusErr = errQ;
        nextState      = ST_IRQ;
      end
      ST_IRQ: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign irq = (state == ST_IRQ) && irqEnable;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      idxQ      <= '0;
      issueDone <= 1'b0;
      errQ      <= 1'b0;
    end else begin
      state <= nextState;
      if (nextState != state) begin
        idxQ      <= '0;
        issueDone <= 1'b0;
      end else if (strb.rdBlock || strb.rdPacket) begin
        if (idxQ == lastIdx) issueDone <= 1'b1;
        else                 idxQ      <= idxQ + IDX_W'(1);
      end
      if (strb.takePtr)   errQ <= 1'b0;
      else if (badLenHit) errQ <= 1'b1;
    end
  end

  // R7: the completion pulse lasts exactly one cycle
  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);
  // R7: no interrupt while the enable is off
  p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> irqEnable);
  // R6: a rejected length never leads to packet reads or a reply
  p_err_no_packet_r6: assert property (@(posedge clk) disable iff (!rstN)
    errQ |-> !(strb.rdPacket || strb.wrReply));
  // R10: the status write is always followed by the interrupt slot
  p_status_then_irq_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrStatus |=> (state == ST_IRQ));
endmodule

// File: rtl/mbox_dp.sv
module mbox_dp
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrEn,
  input  logic [ADDR_W-1:0] cmdWrData,
  output logic              cmdReady,
  output logic              cmdOverrun,
  output logic              pendValid,
  input  seqStrobe_t        strb,
  output logic              rxValid,
  output logic [IDX_W-1:0]  rxIdx,
  output logic              pktFlag,
  output logic              lenOk,
  output logic [IDX_W-1:0]  pktWords,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWrData,
  input  logic [31:0]       memRdData
);
  logic [ADDR_W-1:0] pendPtr, blockPtr, pktPtr;
  logic              overrunQ, rxPkt;
  logic [7:0]        opcode;
  logic [15:0]       pktLen;
  logic [31:0]       acc, result;
  logic [16:0]       lenPlus;

  assign cmdReady   = !pendValid;
  assign cmdOverrun = overrunQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendPtr   <= '0;
      overrunQ  <= 1'b0;
      blockPtr  <= '0;
    end else begin
      if (cmdWrEn && !pendValid) begin
        pendValid <= 1'b1;
        pendPtr   <= cmdWrData;
      end else if (strb.takePtr) begin
        pendValid <= 1'b0;
        blockPtr  <= pendPtr;
      end
      if (cmdWrEn && pendValid) overrunQ <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxValid <= 1'b0;
      rxIdx   <= '0;
      rxPkt   <= 1'b0;
      opcode  <= '0;
      pktFlag <= 1'b0;
      pktPtr  <= '0;
      pktLen  <= '0;
      acc     <= '0;
      result  <= '0;
    end else begin
      rxValid <= strb.rdBlock || strb.rdPacket;
      rxIdx   <= strb.idx;
      rxPkt   <= strb.rdPacket;
      if (rxValid && !rxPkt) begin
        case (rxIdx)
          IDX_W'(0): begin
            opcode  <= memRdData[7:0];
            pktFlag <= memRdData[8];
          end
          IDX_W'(1): pktPtr <= memRdData[ADDR_W-1:0];
          IDX_W'(2): pktLen <= memRdData[15:0];
          default: ;
        endcase
      end
      if (strb.takePtr)         acc <= '0;
      else if (rxValid && rxPkt) acc <= acc + memRdData;
      if (strb.latchExec) result <= acc + {24'b0, opcode};
    end
  end

  assign lenOk    = (pktLen >= 16'(MIN_LEN)) && (pktLen <= 16'(MAX_LEN));
  assign lenPlus  = {1'b0, pktLen} + 17'd3;
  assign pktWords = lenPlus[IDX_W+1:2];

  always_comb begin
    memRdEn   = strb.rdBlock || strb.rdPacket;
    memWrEn   = strb.wrReply || strb.wrStatus;
    memAddr   = '0;
    memWrData = '0;
    if (strb.rdBlock)
      memAddr = blockPtr + ADDR_W'({strb.idx, 2'b00});
    else if (strb.rdPacket)
      memAddr = pktPtr + ADDR_W'({strb.idx, 2'b00});
    else if (strb.wrReply) begin
      memAddr   = pktPtr + ADDR_W'({pktWords, 2'b00});
      memWrData = result;
    end else if (strb.wrStatus) begin
      memAddr   = blockPtr + ADDR_W'(RESP_OFFSET);
      memWrData = {24'b0, strb.statusErr ? CODE_BADLEN : CODE_OK};
    end
  end

  // R1: an accepted write makes the register busy in the next cycle
  p_ready_drop_r1: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrEn && cmdReady) |=> !cmdReady);
  // R2: taking the pointer frees the register
  p_ready_after_take_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.takePtr |=> cmdReady);
  // R8: a write into a full register raises the overrun flag
  p_overrun_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrEn && !cmdReady) |=> cmdOverrun);
  // R8: the overrun flag is sticky
  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    cmdOverrun |=> cmdOverrun);
  // R8: a rejected write leaves the pending pointer untouched
  p_pend_kept_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrEn && pendValid && !strb.takePtr) |=> $stable(pendPtr));
  // R3: one memory access per cycle
  p_one_access_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdEn && memWrEn));
endmodule

// File: rtl/mbox_cmd_seq.sv
module mbox_cmd_seq
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrEn,
  input  logic [ADDR_W-1:0] cmdWrData,
  output logic              cmdReady,
  output logic              cmdOverrun,
  input  logic              irqEnable,
  output logic              irq,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWrData,
  input  logic [31:0]       memRdData
);
  seqStrobe_t       strb;
  logic             pendValid, rxValid, pktFlag, lenOk;
  logic [IDX_W-1:0] rxIdx, pktWords;

  mbox_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pendValid (pendValid),
    .irqEnable (irqEnable),
    .rxValid   (rxValid),
    .rxIdx     (rxIdx),
    .pktFlag   (pktFlag),
    .lenOk     (lenOk),
    .pktWords  (pktWords),
    .strb      (strb),
    .irq       (irq)
  );

  mbox_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cmdWrEn    (cmdWrEn),
    .cmdWrData  (cmdWrData),
    .cmdReady   (cmdReady),
    .cmdOverrun (cmdOverrun),
    .pendValid  (pendValid),
    .strb       (strb),
    .rxValid    (rxValid),
    .rxIdx      (rxIdx),
    .pktFlag    (pktFlag),
    .lenOk      (lenOk),
    .pktWords   (pktWords),
    .memRdEn    (memRdEn),
    .memWrEn    (memWrEn),
    .memAddr    (memAddr),
    .memWrData  (memWrData),
    .memRdData  (memRdData)
  );

  // R10: the interrupt always directly follows a memory write (the status word)
  p_irq_after_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $past(memWrEn));
endmodule

// File: tb/mbox_cmd_seq_tb.sv
module mbox_cmd_seq_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdWrEn = 1'b0;
  logic [31:0] cmdWrData = '0;
  logic        cmdReady, cmdOverrun, irq;
  logic        irqEnable = 1'b1;
  logic        memRdEn, memWrEn;
  logic [31:0] memAddr, memWrData;
  logic [31:0] memRdData = '0;

  logic [31:0] mem [0:1023];
  logic [63:0] expQ [$];
  string       tagQ [$];
  int checks = 0, fails = 0, irqSeen = 0, irqExp = 0;
  int pktReads = 0, blkReads = 0;
  logic prevWr = 1'b0;

  always #2 clk = ~clk;

  mbox_cmd_seq u_dut (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData),
    .cmdReady(cmdReady), .cmdOverrun(cmdOverrun), .irqEnable(irqEnable),
    .irq(irq), .memRdEn(memRdEn), .memWrEn(memWrEn), .memAddr(memAddr),
    .memWrData(memWrData), .memRdData(memRdData)
  );

  always @(posedge clk) begin
    if (memRdEn) memRdData <= mem[memAddr[11:2]];
    if (memWrEn) mem[memAddr[11:2]] <= memWrData;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected writes and checks interrupt placement
  always @(negedge clk) begin
    if (rstN) begin
      if (memWrEn) begin
        if (expQ.size() == 0)
          check(1'b0, "R6/R9 unexpected write", {memAddr, memWrData}, 64'h0);
        else begin
          automatic logic [63:0] e = expQ.pop_front();
          automatic string t = tagQ.pop_front();
          check({memAddr, memWrData} == e, t, {memAddr, memWrData}, e);
        end
      end
      if (irq) begin
        irqSeen++;
        check(prevWr, "R10 irq after status", 64'(prevWr), 64'd1);
      end
      prevWr = memWrEn;
    end
  end

  task automatic pushExp(input logic [31:0] a, input logic [31:0] d, input string t);
    expQ.push_back({a, d});
    tagQ.push_back(t);
  endtask

  // builds a command in memory and queues its expected writes
  task automatic buildCmd(input logic [31:0] blk, input logic [7:0] op, input bit pkt,
                          input logic [31:0] pp, input int len);
    automatic logic [31:0] sum = 0;
    automatic int words = (len + 3) / 4;
    mem[blk[11:2]]     = {23'b0, pkt, op};
    mem[blk[11:2] + 1] = pp;
    mem[blk[11:2] + 2] = 32'(len);
    for (int i = 3; i < 8; i++) mem[blk[11:2] + 10'(i)] = 32'hDEAD0000 + 32'(i);
    if (pkt && len >= 4 && len <= 248) begin
      for (int i = 0; i < words; i++) begin
        mem[pp[11:2] + 10'(i)] = 32'h9E3779B9 * 32'(i + 1) + {24'b0, op};
        sum += mem[pp[11:2] + 10'(i)];
      end
      pushExp(pp + 32'(4 * words), sum + {24'b0, op}, "R5 reply word");
      pushExp(blk + 28, 32'h1, "R6 success code");
    end else if (pkt) begin
      pushExp(blk + 28, 32'h80, "R6 bad length code");
    end else begin
      pushExp(blk + 28, 32'h1, "R9 inline success code");
    end
    if (irqEnable) irqExp++;
  endtask

  task automatic sendPtr(input logic [31:0] p);
    @(negedge clk);
    cmdWrEn = 1'b1; cmdWrData = p;
    @(negedge clk);
    cmdWrEn = 1'b0;
  endtask

  task automatic waitDone();
    while (expQ.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // count reads per region to check R3/R4/R6
  logic [31:0] watchBase = 32'hFFFF_FFFF;
  always @(negedge clk)
    if (rstN && memRdEn && memAddr >= watchBase && memAddr < watchBase + 32'h100) pktReads++;

  task automatic runPkt(input logic [31:0] blk, input logic [31:0] pp, input int len, input logic [7:0] op);
    buildCmd(blk, op, 1'b1, pp, len);
    watchBase = pp; pktReads = 0;
    sendPtr(blk);
    waitDone();
    if (len >= 4 && len <= 248)
      check(pktReads == (len + 3) / 4, "R4 packet read count", 64'(pktReads), 64'((len + 3) / 4));
    else
      check(pktReads == 0, "R6 no packet read", 64'(pktReads), 64'd0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(cmdReady == 1'b1, "R11 ready", 64'(cmdReady), 64'd1);
    check(cmdOverrun == 1'b0, "R11 overrun", 64'(cmdOverrun), 64'd0);
    check(irq == 1'b0, "R11 irq", 64'(irq), 64'd0);
    check(!memRdEn && !memWrEn, "R11 mem idle", {62'b0, memRdEn, memWrEn}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R9 inline command; R1/R2 ready timing; R3 block read count
    buildCmd(32'h040, 8'h05, 1'b0, 32'h0, 0);
    watchBase = 32'h040; pktReads = 0;
    @(negedge clk);
    cmdWrEn = 1'b1; cmdWrData = 32'h040;
    @(negedge clk);
    cmdWrEn = 1'b0;
    check(cmdReady == 1'b0, "R1 busy after accept", 64'(cmdReady), 64'd0);
    @(negedge clk);
    check(cmdReady == 1'b1, "R2 ready once started", 64'(cmdReady), 64'd1);
    waitDone();
    blkReads = pktReads;
    check(blkReads == 8, "R3 block read count", 64'(blkReads), 64'd8);
    check(irqSeen == irqExp, "R7 irq count", 64'(irqSeen), 64'(irqExp));

    // R4/R5 assorted lengths, including the bounds and rounding
    runPkt(32'h080, 32'h100, 16, 8'h11);
    runPkt(32'h0A0, 32'h200, 5, 8'h22);
    runPkt(32'h0C0, 32'h300, 4, 8'h33);
    runPkt(32'h0E0, 32'h400, 248, 8'h44);
    // R6 lengths out of range
    runPkt(32'h500, 32'h600, 2, 8'h55);
    runPkt(32'h520, 32'h700, 252, 8'h66);
    check(irqSeen == irqExp, "R7 irq count enabled", 64'(irqSeen), 64'(irqExp));

    // R7 interrupt disabled
    irqEnable = 1'b0;
    runPkt(32'h540, 32'h800, 12, 8'h77);
    check(irqSeen == irqExp, "R7 no irq when disabled", 64'(irqSeen), 64'(irqExp));
    irqEnable = 1'b1;

    // R8/R2 queueing and overrun
    buildCmd(32'h900, 8'h88, 1'b1, 32'hA00, 248);
    buildCmd(32'h920, 8'h99, 1'b1, 32'hB00, 8);
    mem[32'h940 >> 2] = {23'b0, 1'b0, 8'hAA};
    sendPtr(32'h900);
    repeat (3) @(negedge clk);
    check(cmdReady == 1'b1, "R2 ready while running", 64'(cmdReady), 64'd1);
    cmdWrEn = 1'b1; cmdWrData = 32'h920;
    @(negedge clk);
    check(cmdReady == 1'b0, "R8 full while queued", 64'(cmdReady), 64'd0);
    cmdWrData = 32'h940;
    @(negedge clk);
    cmdWrEn = 1'b0;
    check(cmdOverrun == 1'b1, "R8 overrun set", 64'(cmdOverrun), 64'd1);
    waitDone();
    repeat (40) @(negedge clk);
    check(expQ.size() == 0, "R2 queued command ran", 64'(expQ.size()), 64'd0);
    check(cmdOverrun == 1'b1, "R8 overrun sticky", 64'(cmdOverrun), 64'd1);
    check(irqSeen == irqExp, "R7 irq count final", 64'(irqSeen), 64'(irqExp));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule